// File: doc/BRIEF.md
# Memory-Fetched Descriptor DMA Channel Set

This block holds a set of independent memory-to-memory copy channels. Software writes the memory address of a four-word descriptor into a channel, then sets the channel's run bit. The channel fetches the descriptor over the shared memory port. The four words, at increasing addresses, are a transfer-info word, a source address, a destination address and a byte count. The channel then copies the data one 32-bit word at a time, with one read followed by one write for each word.

Each channel can raise a sticky completion flag, which software clears by writing one to it. A read-only summary word gathers the flags of all channels. The low-numbered channels each drive their own interrupt line. The remaining channels share one interrupt line, which is the OR of their flags.

All channels share one word-wide memory master port. A rotating arbiter grants that port to one access at a time.

Top module: `dma_cb_engine`

## Requirements
- R1: Channel n's registers sit at address n*0x100: offset 0x00 is control/status and offset 0x04 is the descriptor address. The summary word sits at 0xFE0. Register reads are combinational, so reg_rdata reflects reg_addr in the same cycle.
- R2: After reset, every control/status register and the summary word read 0, and all interrupt outputs are low.
- R3: Writing control/status with bit 0 = 1 to an idle channel starts it. Bit 0 (the run bit) reads 1 from the next cycle on. The channel fetches the words at D, D+4, D+8 and D+12, where D is the descriptor address, and takes them as info, source, destination and byte count.
- R4: The channel copies count/4 words, with the low two bits of the count ignored. Each word is read from the source address and then written to the destination address. After each word the destination advances by 4 if info bit 4 is set, and the source advances by 4 if info bit 8 is set. An address that does not advance stays fixed for the whole transfer.
- R5: The run bit clears on the clock edge at which the last word's write completes. A count below 4 ends the transfer right after the descriptor fetch, with no data access.
- R6: Control/status bit 2 (the completion flag) becomes 1 at the end of the transfer if info bit 0 is set. It stays 0 if info bit 0 is clear.
- R7: A control/status write with bit 2 = 1 clears the flag, and a write with bit 2 = 0 leaves it unchanged. A write with bit 0 = 1 to a busy channel does not restart it or change its timing.
- R8: Bit n of the summary word equals channel n's flag. Writes to the summary word have no effect.
- R9: irq_o[k] is high exactly when channel k's flag is set, for k below IRQ_DED (11). irq_shared_o is the OR of the flags of channels IRQ_DED to NUM_CH-1.
- R10: The memory port carries one access at a time. A pending access holds its address, direction and data until mem_ready. After each access, the grant goes to the next requesting channel in ascending index order, wrapping around past the last channel.
- R11: With mem_ready held high, each memory access takes 2 cycles. A transfer of N words therefore clears its run bit 2*(4+2N) cycles after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this edge |
| irq_o | output | 11 | Dedicated per-channel interrupt lines |
| irq_shared_o | output | 1 | Shared interrupt line of the upper channels |

## Verification
Register reads have no latency, so the bench sets an address on the falling edge and samples reg_rdata 1 ns later. After a start write, the run bit is due one cycle later. With an always-ready memory, the run bit must drop exactly 2*(4+2N) cycles after the start write, and the bench counts falling edges to check that cycle precisely, including a restart attempt in mid-transfer. The flag, the summary bit and the interrupt line all change at the same edge as the run bit, and the bench checks them only after the run bit is seen low. Randomized runs with stalled memory poll the run bits with a bounded count, then compare every destination word against a bench model of the address stepping.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;

  typedef enum logic [2:0] {
    CH_IDLE,
    CH_CB_INFO,
    CH_CB_SRC,
    CH_CB_DST,
    CH_CB_LEN,
    CH_READ,
    CH_WRITE
  } ch_state_e;

  localparam int CS_RUN_BIT   = 0;
  localparam int CS_FLAG_BIT  = 2;
  localparam int INFO_IE_BIT  = 0;
  localparam int INFO_DI_BIT  = 4;
  localparam int INFO_SI_BIT  = 8;
  localparam logic [7:0]  OFF_CS   = 8'h00;
  localparam logic [7:0]  OFF_CBA  = 8'h04;
  localparam logic [11:0] GSTAT_ADDR = 12'hFE0;

endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             xfer_done,
  output logic             busy_o,
  output logic [$clog2(N)-1:0] owner_o,
  output logic [N-1:0]     grant_o
);
  localparam int IW = $clog2(N);

  logic          busy_q, busy_d;
  logic [IW-1:0] owner_q, owner_d;
  logic [IW-1:0] last_q, last_d;
  logic          pick_vld;
  logic [IW-1:0] pick;

  // rotating search starting just above the last granted channel
  always_comb begin
    pick_vld = 1'b0;
    pick     = last_q;
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = int'(last_q) + i;
      if (idx >= N) idx = idx - N;
      if (!pick_vld && req[idx]) begin
        pick_vld = 1'b1;
        pick     = IW'(idx);
      end
    end
  end

  always_comb begin
    busy_d  = busy_q;
    owner_d = owner_q;
    last_d  = last_q;
    if (!busy_q) begin
      if (pick_vld) begin
        busy_d  = 1'b1;
        owner_d = pick;
      end
    end else if (xfer_done) begin
      busy_d = 1'b0;
      last_d = owner_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      last_q  <= IW'(N - 1);
    end else begin
      busy_q  <= busy_d;
      owner_q <= owner_d;
      last_q  <= last_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_grant
      assign grant_o[g] = busy_q && (owner_q == IW'(g));
    end
  endgenerate

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

endmodule

// File: rtl/dma_cb_channel.sv
module dma_cb_channel
  import dma_cb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_wr,
  input  logic          cba_wr,
  input  logic [DW-1:0] wdata,
  input  logic          ack,
  input  logic [DW-1:0] rdata,
  output logic          req,
  output logic          req_we,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic          active,
  output logic          flag,
  output logic          done,
  output logic [DW-1:0] cb_addr
);
  localparam int WCW = DW - 2;

  ch_state_e      st_q, st_d;
  logic [DW-1:0]  cba_q, cba_d;
  logic           ie_q, ie_d, si_q, si_d, di_q, di_d;
  logic [DW-1:0]  src_q, src_d, dst_q, dst_d, buf_q, buf_d;
  logic [WCW-1:0] wc_q, wc_d;
  logic           flag_q, flag_d;
  logic           end_xfer;

  always_comb begin
    st_d     = st_q;
    cba_d    = cba_q;
    ie_d     = ie_q;
    si_d     = si_q;
    di_d     = di_q;
    src_d    = src_q;
    dst_d    = dst_q;
    wc_d     = wc_q;
    buf_d    = buf_q;
    end_xfer = 1'b0;
    case (st_q)
      CH_IDLE: begin
        if (cba_wr) cba_d = wdata;
        if (cs_wr && wdata[CS_RUN_BIT]) st_d = CH_CB_INFO;
      end
      CH_CB_INFO: if (ack) begin
        ie_d = rdata[INFO_IE_BIT];
        di_d = rdata[INFO_DI_BIT];
        si_d = rdata[INFO_SI_BIT];
        st_d = CH_CB_SRC;
      end
      CH_CB_SRC: if (ack) begin
        src_d = rdata;
        st_d  = CH_CB_DST;
      end
      CH_CB_DST: if (ack) begin
        dst_d = rdata;
        st_d  = CH_CB_LEN;
      end
      CH_CB_LEN: if (ack) begin
        wc_d = rdata[DW-1:2];
        if (rdata[DW-1:2] == '0) begin
          st_d     = CH_IDLE;
          end_xfer = 1'b1;
        end else begin
          st_d = CH_READ;
        end
      end
      CH_READ: if (ack) begin
        buf_d = rdata;
        st_d  = CH_WRITE;
      end
      CH_WRITE: if (ack) begin
        if (si_q) src_d = src_q + DW'(4);
        if (di_q) dst_d = dst_q + DW'(4);
        wc_d = wc_q - WCW'(1);
        if (wc_q == WCW'(1)) begin
          st_d     = CH_IDLE;
          end_xfer = 1'b1;
        end else begin
          st_d = CH_READ;
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  // completion set takes priority over a clear in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (end_xfer && ie_q)                flag_d = 1'b1;
    else if (cs_wr && wdata[CS_FLAG_BIT]) flag_d = 1'b0;
  end

  always_comb begin
    case (st_q)
      CH_CB_INFO: req_addr = cba_q;
      CH_CB_SRC:  req_addr = cba_q + DW'(4);
      CH_CB_DST:  req_addr = cba_q + DW'(8);
      CH_CB_LEN:  req_addr = cba_q + DW'(12);
      CH_READ:    req_addr = src_q;
      CH_WRITE:   req_addr = dst_q;
      default:    req_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      cba_q  <= '0;
      ie_q   <= 1'b0;
      si_q   <= 1'b0;
      di_q   <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      wc_q   <= '0;
      buf_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cba_q  <= cba_d;
      ie_q   <= ie_d;
      si_q   <= si_d;
      di_q   <= di_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      wc_q   <= wc_d;
      buf_q  <= buf_d;
      flag_q <= flag_d;
    end
  end

  assign req       = (st_q != CH_IDLE);
  assign req_we    = (st_q == CH_WRITE);
  assign req_wdata = buf_q;
  assign active    = (st_q != CH_IDLE);
  assign flag      = flag_q;
  assign done      = end_xfer;
  assign cb_addr   = cba_q;

endmodule

// File: rtl/dma_irq_map.sv
module dma_irq_map #(
  parameter int N    = 15,
  parameter int NDED = 11
) (
  input  logic [N-1:0]    flags,
  output logic [NDED-1:0] irq_o,
  output logic            irq_shared_o
);
  genvar g;
  generate
    for (g = 0; g < NDED; g++) begin : g_ded
      if (g < N) begin : g_on
        assign irq_o[g] = flags[g];
      end else begin : g_off
        assign irq_o[g] = 1'b0;
      end
    end
    if (N > NDED) begin : g_shared
      assign irq_shared_o = |flags[N-1:NDED];
    end else begin : g_noshared
      assign irq_shared_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dma_cb_engine.sv
module dma_cb_engine
  import dma_cb_pkg::*;
#(
  parameter int NUM_CH  = 15,
  parameter int IRQ_DED = 11,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [11:0]        reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               mem_ready,
  output logic [IRQ_DED-1:0] irq_o,
  output logic               irq_shared_o
);
  localparam int IW = $clog2(NUM_CH);

  logic [3:0] sel_ch;
  logic [7:0] sel_off;
  assign sel_ch  = reg_addr[11:8];
  assign sel_off = reg_addr[7:0];

  logic [NUM_CH-1:0] ch_req, ch_we, ch_active, ch_flag, ch_done, ch_ack;
  logic [NUM_CH-1:0] cs_wr, cba_wr, arb_grant;
  logic [DW-1:0]     ch_addr  [NUM_CH];
  logic [DW-1:0]     ch_wdata [NUM_CH];
  logic [DW-1:0]     ch_cba   [NUM_CH];
  logic              arb_busy;
  logic [IW-1:0]     arb_owner;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      assign cs_wr[g]  = reg_wr && (sel_ch == 4'(g)) && (sel_off == OFF_CS);
      assign cba_wr[g] = reg_wr && (sel_ch == 4'(g)) && (sel_off == OFF_CBA);
      assign ch_ack[g] = arb_grant[g] && mem_ready;

      dma_cb_channel #(.DW(DW)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_wr    (cs_wr[g]),
        .cba_wr   (cba_wr[g]),
        .wdata    (reg_wdata),
        .ack      (ch_ack[g]),
        .rdata    (mem_rdata),
        .req      (ch_req[g]),
        .req_we   (ch_we[g]),
        .req_addr (ch_addr[g]),
        .req_wdata(ch_wdata[g]),
        .active   (ch_active[g]),
        .flag     (ch_flag[g]),
        .done     (ch_done[g]),
        .cb_addr  (ch_cba[g])
      );
    end
  endgenerate

  dma_rr_arb #(.N(NUM_CH)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (ch_req),
    .xfer_done(mem_ready),
    .busy_o   (arb_busy),
    .owner_o  (arb_owner),
    .grant_o  (arb_grant)
  );

  assign mem_req   = arb_busy;
  assign mem_we    = arb_busy && ch_we[arb_owner];
  assign mem_addr  = ch_addr[arb_owner];
  assign mem_wdata = ch_wdata[arb_owner];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == GSTAT_ADDR) begin
      reg_rdata = DW'(ch_flag);
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (sel_ch == 4'(n)) begin
          if (sel_off == OFF_CS) begin
            reg_rdata[CS_RUN_BIT]  = ch_active[n];
            reg_rdata[CS_FLAG_BIT] = ch_flag[n];
          end else if (sel_off == OFF_CBA) begin
            reg_rdata = ch_cba[n];
          end
        end
      end
    end
  end

  dma_irq_map #(.N(NUM_CH), .NDED(IRQ_DED)) u_irq (
    .flags       (ch_flag),
    .irq_o       (irq_o),
    .irq_shared_o(irq_shared_o)
  );

endmodule

// File: rtl/dma_cb_checker.sv
module dma_cb_checker #(
  parameter int NUM_CH  = 15,
  parameter int IRQ_DED = 11,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [11:0]        reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic               mem_req,
  input logic               mem_we,
  input logic [DW-1:0]      mem_addr,
  input logic [DW-1:0]      mem_wdata,
  input logic               mem_ready,
  input logic [IRQ_DED-1:0] irq_o,
  input logic [NUM_CH-1:0]  ch_active,
  input logic [NUM_CH-1:0]  ch_flag,
  input logic [NUM_CH-1:0]  ch_done,
  input logic [NUM_CH-1:0]  arb_grant
);
  // R10: a stalled access keeps its attributes
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: at most one channel owns the port
  assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_grant));

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_chk
      // R6: the flag only rises as the transfer ends
      assert_flag_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_flag[g]) |-> $fell(ch_active[g]));
      // R5: the run bit drops only on a completed memory access
      assert_end_on_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_active[g]) |-> $past(mem_req && mem_ready));
      // R7: write-one clears the flag
      assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_flag[g] && reg_wr && reg_addr == 12'(g * 256) && reg_wdata[2] && !ch_done[g]) |=> !ch_flag[g]);
      if (g < IRQ_DED) begin : g_irq
        // R9: a dedicated line rises only as its channel finishes
        assert_irq_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
          $rose(irq_o[g]) |-> $fell(ch_active[g]));
      end
    end
  endgenerate

endmodule

bind dma_cb_engine dma_cb_checker #(.NUM_CH(NUM_CH), .IRQ_DED(IRQ_DED), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ready(mem_ready),
  .irq_o    (irq_o),
  .ch_active(ch_active),
  .ch_flag  (ch_flag),
  .ch_done  (ch_done),
  .arb_grant(arb_grant)
);

// File: tb/dma_cb_engine_tb.sv
`timescale 1ns/1ps
module dma_cb_engine_tb;
  localparam int NCH  = 15;
  localparam int NDED = 11;
  localparam int MW   = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [NDED-1:0] irq_o;
  logic        irq_shared_o;

  logic [31:0] mem [MW];
  bit          stall_en;
  int          n_chk, n_fail, cyc;
  bit          log_en;
  int          log_n;
  logic [31:0] log_a [12];

  always #2.5 clk = ~clk;

  dma_cb_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq_o(irq_o),
    .irq_shared_o(irq_shared_o)
  );

  assign mem_rdata = mem[mem_addr[13:2]];

  always @(negedge clk) mem_ready <= stall_en ? (($urandom % 4) != 0) : 1'b1;

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
    if (log_en && mem_req && mem_ready && log_n < 12) begin
      log_a[log_n] = mem_addr;
      log_n++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected < 150000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [11:0] cs_a(input int ch);
    return 12'(ch * 256);
  endfunction

  task automatic put_cb(input int cb, input logic [31:0] info, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] len);
    mem[cb/4] = info; mem[cb/4+1] = s; mem[cb/4+2] = d; mem[cb/4+3] = len;
  endtask

  task automatic wait_idle(input int ch);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(cs_a(ch), v);
      if (v[0] == 1'b0) return;
    end
  endtask

  task automatic run_ch(input int ch, input int cb, input logic [31:0] info,
                        input logic [31:0] s, input logic [31:0] d, input logic [31:0] len);
    put_cb(cb, info, s, d, len);
    wr(cs_a(ch) + 12'h4, 32'(cb));
    wr(cs_a(ch), 32'h1);
    wait_idle(ch);
  endtask

  // model of one destination word after a transfer of n words
  function automatic logic [31:0] exp_dst(input int j, input int n, input bit si, input bit di,
                                          input logic [31:0] sbase_w, input logic [31:0] mark);
    int sw;
    if (di) begin
      if (j >= n) return mark;
      sw = si ? j : 0;
    end else begin
      if (j != 0 || n == 0) return mark;
      sw = si ? n - 1 : 0;
    end
    return mem[sbase_w + 32'(sw)];
  endfunction

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED1234));
    n_chk = 0; n_fail = 0; cyc = 0; log_en = 0; log_n = 0;
    stall_en = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    for (int i = 0; i < MW; i++) mem[i] = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    for (int c = 0; c < NCH; c++) begin
      rd(cs_a(c), v);
      chk("R2 cs reset", v, 0);
    end
    rd(12'hFE0, v); chk("R2 summary reset", v, 0);
    chk("R2 irq reset", {irq_shared_o, irq_o}, 0);

    // R1: descriptor address readback
    wr(cs_a(3) + 12'h4, 32'h0000_0ABC);
    rd(cs_a(3) + 12'h4, v); chk("R1 cb addr readback", v, 32'h0000_0ABC);

    // R11/R3/R7: exact timing with a restart attempt while busy, 8 words
    mem[32/4] = 32'h1234_5678;
    for (int w = 1; w < 8; w++) mem[32/4 + w] = ~32'h1234_5678;
    put_cb(256, 32'h111, 32, 64, 32);
    wr(12'h004, 256);
    wr(12'h000, 32'h1);
    begin
      int first0;
      first0 = -1;
      for (int j = 0; j < 100 && first0 < 0; j++) begin
        reg_addr = 12'h000;
        if (j == 5) begin reg_wr = 1'b1; reg_wdata = 32'h1; end
        else reg_wr = 1'b0;
        #1;
        if (j == 0) chk("R3 run bit set next cycle", reg_rdata[0], 1);
        if (reg_rdata[0] == 1'b0) first0 = j;
        @(negedge clk);
      end
      reg_wr = 1'b0;
      chk("R11 R7 end cycle", 32'(first0), 40);
    end
    for (int w = 0; w < 8; w++)
      chk("R4 inc copy", mem[64/4 + w], mem[32/4 + w]);
    rd(12'h000, v); chk("R6 flag set", v, 32'h4);
    rd(12'hFE0, v); chk("R8 summary bit0", v, 32'h1);
    chk("R9 irq0", 32'(irq_o), 1);
    wr(12'hFE0, 32'h0);
    rd(12'hFE0, v); chk("R8 summary write ignored", v, 32'h1);
    wr(12'h000, 32'h0);
    rd(12'h000, v); chk("R7 write0 keeps flag", v, 32'h4);
    wr(12'h000, 32'h4);
    rd(12'h000, v); chk("R7 write1 clears", v, 32'h0);
    chk("R9 irq0 cleared", 32'(irq_o), 0);

    // R9: channel 10 dedicated, 11 and 14 shared
    run_ch(10, 512, 32'h111, 32, 128, 8);
    chk("R9 irq10", 32'(irq_o), 32'h400);
    chk("R9 shared low", irq_shared_o, 0);
    wr(cs_a(10), 32'h4);
    run_ch(11, 512, 32'h111, 32, 128, 8);
    chk("R9 shared from 11", irq_shared_o, 1);
    chk("R9 no dedicated", 32'(irq_o), 0);
    rd(12'hFE0, v); chk("R8 summary bit11", v, 32'h800);
    wr(cs_a(11), 32'h4);
    chk("R9 shared cleared", irq_shared_o, 0);
    run_ch(14, 512, 32'h111, 32, 128, 8);
    chk("R9 shared from 14", irq_shared_o, 1);
    rd(12'hFE0, v); chk("R8 summary bit14", v, 32'h4000);
    wr(cs_a(14), 32'h4);

    // R4: fixed source / fixed destination; R6 no flag without bit0
    for (int w = 0; w < 4; w++) mem[1024/4 + w] = 32'hA000_0000 + 32'(w);
    for (int w = 0; w < 4; w++) mem[1536/4 + w] = 32'hDEAD_0000;
    run_ch(2, 768, 32'h010, 1024, 1536, 16);
    for (int w = 0; w < 4; w++) chk("R4 fixed src", mem[1536/4 + w], 32'hA000_0000);
    rd(cs_a(2), v); chk("R6 no flag when disabled", v, 0);
    for (int w = 0; w < 4; w++) mem[1536/4 + w] = 32'hDEAD_0000;
    run_ch(2, 768, 32'h100, 1024, 1536, 16);
    chk("R4 fixed dst last word", mem[1536/4], 32'hA000_0003);
    chk("R4 fixed dst others untouched", mem[1536/4 + 1], 32'hDEAD_0000);

    // R5: zero length ends after the descriptor, no data written
    mem[1536/4] = 32'hDEAD_0000;
    run_ch(4, 768, 32'h111, 1024, 1536, 0);
    chk("R5 zero length no write", mem[1536/4], 32'hDEAD_0000);
    rd(cs_a(4), v); chk("R5 zero length done with flag", v, 32'h4);
    wr(cs_a(4), 32'h4);

    // R10: round-robin ordering of descriptor fetches
    put_cb(32'h100, 0, 0, 0, 0); put_cb(32'h200, 0, 0, 0, 0); put_cb(32'h300, 0, 0, 0, 0);
    wr(cs_a(0) + 12'h4, 32'h100);
    wr(cs_a(1) + 12'h4, 32'h200);
    wr(cs_a(2) + 12'h4, 32'h300);
    log_n = 0; log_en = 1;
    @(negedge clk); reg_wr = 1; reg_wdata = 1; reg_addr = cs_a(2);
    @(negedge clk); reg_addr = cs_a(0);
    @(negedge clk); reg_addr = cs_a(1);
    @(negedge clk); reg_wr = 0;
    repeat (40) @(negedge clk);
    log_en = 0;
    chk("R10 order 0", log_a[0], 32'h300);
    chk("R10 order 1", log_a[1], 32'h100);
    chk("R10 order 2", log_a[2], 32'h200);
    chk("R10 order 3", log_a[3], 32'h304);
    chk("R10 order 4", log_a[4], 32'h104);
    chk("R10 order 5", log_a[5], 32'h204);

    // R4/R6/R10: random concurrent transfers with memory stalls
    stall_en = 1;
    for (int r = 0; r < 6; r++) begin
      int  chs [4];
      int  nw [4];
      bit  si [4], di [4], ie [4];
      for (int k = 0; k < 4; k++) begin
        chs[k] = (r + 4 * k) % NCH;
        nw[k]  = $urandom % 9;
        si[k]  = 1'($urandom); di[k] = 1'($urandom); ie[k] = 1'($urandom);
        for (int w = 0; w < 9; w++) begin
          mem[(32'h2000 + k * 32'h400) / 4 + w] = $urandom;
          mem[(32'h3000 + k * 32'h400) / 4 + w] = 32'hCAFE_0000 + 32'(w);
        end
        put_cb(32'h1000 + k * 32'h40, {23'b0, si[k], 3'b0, di[k], 3'b0, ie[k]},
               32'h2000 + k * 32'h400, 32'h3000 + k * 32'h400, 32'(nw[k] * 4));
        wr(cs_a(chs[k]) + 12'h4, 32'h1000 + k * 32'h40);
      end
      for (int k = 0; k < 4; k++) wr(cs_a(chs[k]), 32'h1);
      for (int k = 0; k < 4; k++) wait_idle(chs[k]);
      for (int k = 0; k < 4; k++) begin
        for (int j = 0; j < 9; j++)
          chk("R4 random dst", mem[(32'h3000 + k * 32'h400) / 4 + j],
              exp_dst(j, nw[k], si[k], di[k], (32'h2000 + k * 32'h400) / 4, 32'hCAFE_0000 + 32'(j)));
        rd(cs_a(chs[k]), v);
        chk("R6 random flag", v, {29'b0, ie[k], 2'b0});
        wr(cs_a(chs[k]), 32'h4);
      end
    end
    stall_en = 0;
    rd(12'hFE0, v); chk("R8 summary clear at end", v, 0);

    summary();
  end

endmodule